// File: doc/BRIEF.md
# Downstream Frame Forwarder with Per-Node Record Extraction

This block lives on the downstream path of a node in a line of cascaded nodes. One received byte stream feeds two channels at the same time. The forwarding channel copies every byte, and its start and end markers, to the outgoing port after a fixed delay. It changes nothing. The analysis channel walks the operation records that follow the frame header. A record whose target id equals this node's assigned sequence number is unpacked into two write ports. The payload bytes go to the application-data RAM port. The record's RAM address and length go to the operation-info RAM port.

Each record is laid out as follows: one target-id byte, a two-byte RAM address (high byte first), one length byte, then that many payload bytes. A target id of 0xFF closes the record list. Any bytes after it are only forwarded. When a frame ends cleanly, a completion strobe is held high for a fixed number of clocks to tell the local application that new commands are waiting. A frame that arrives with its error flag set at the end marker gives no strobe. Writes already issued for that frame stay in the RAMs.

Top module: `dl_frame_splitter`

## Requirements
- R1: Every accepted input byte appears on the forward outputs exactly 2 clock cycles later, with the same data value and the same start and end markers. The forward outputs show valid low when the input was idle.
- R2: The first HDR_LEN bytes of a frame are header bytes. The first of them is the byte that carries the start marker. None of them is interpreted as a record field, even if its value equals the node id.
- R3: Each payload byte of a matching record produces an application write in the next cycle. The write data is the byte. The write address is the record address plus the byte's offset in the payload, cut to ADDR_W bits.
- R4: A record whose target id differs from node_id is skipped byte by byte over its full length field. It produces neither application writes nor operation writes.
- R5: On the length byte of a matching record, one operation-info write is issued in the next cycle. Its data is {address[15:0], length[7:0]} and its index counts 0, 1, 2 … within the frame. The index restarts at 0 with every start marker.
- R6: A matching record with length 0 produces its operation-info write and no application write. The byte after its length byte is read as the next target id.
- R7: A target id of 0xFF ends the record list. No byte after it in the same frame causes any write.
- R8: The cycle after a byte that carries the end marker of an error-free frame, rx_done goes high and stays high for exactly DONE_CYCLES (12) cycles.
- R9: If in_err is high with the end marker, rx_done is not raised. The application writes made earlier in that frame remain, and the final byte of that frame is still written if it is a matching payload byte.
- R10: While reset is applied, and in the first cycle after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 8 | Sequence number assigned to this node |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_err | input | 1 | Frame check failed; sampled with in_eof |
| fwd_valid | output | 1 | Forwarded byte valid |
| fwd_data | output | 8 | Forwarded byte |
| fwd_sof | output | 1 | Forwarded start marker |
| fwd_eof | output | 1 | Forwarded end marker |
| app_we | output | 1 | Application-data RAM write enable |
| app_addr | output | ADDR_W (8) | Application-data RAM write address |
| app_wdata | output | 8 | Application-data RAM write data |
| op_we | output | 1 | Operation-info RAM write enable |
| op_addr | output | OP_AW (4) | Operation-info RAM entry index |
| op_wdata | output | 24 | Record address (16 bits) and length (8 bits) |
| rx_done | output | 1 | Completion strobe, DONE_CYCLES long |

## Verification
The final payload byte of a matching record can carry the end marker. The application write for that byte and the first cycle of the completion strobe then come out in the same cycle, while the forward outputs still show the byte before it. The vector table ends a frame this way. In the same sampled cycle it checks the write address and data, rx_done high, and the delayed forward beat. The error-terminated frame provokes the same collision, and there the write is expected to appear while rx_done stays low.

// File: rtl/dl_frame_pkg.sv
package dl_frame_pkg;
  localparam int BYTE_W   = 8;
  localparam int RADDR_W  = 16;
  localparam logic [BYTE_W-1:0] LIST_END_ID = 8'hFF;

  typedef enum logic [2:0] {
    W_IDLE,
    W_HEAD,
    W_TGT,
    W_AHI,
    W_ALO,
    W_LEN,
    W_BODY,
    W_TAIL
  } walk_state_t;

  typedef struct packed {
    logic              vld;
    logic              sof;
    logic              eof;
    logic [BYTE_W-1:0] dat;
  } beat_t;
endpackage

// File: rtl/dl_fwd_delay.sv
module dl_fwd_delay #(
  parameter int DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dl_frame_pkg::beat_t  din,
  output dl_frame_pkg::beat_t  dout
);
  import dl_frame_pkg::*;

  beat_t pipe [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[DEPTH-1];

  // A forwarded marker always rides on a valid beat (R1).
  assert_marker_valid_R1: assert property (@(posedge clk) disable iff (rst)
    (dout.sof || dout.eof) |-> dout.vld);
endmodule

// File: rtl/dl_rec_walker.sv
module dl_rec_walker #(
  parameter int HDR_LEN = 2,
  parameter int ADDR_W  = 8,
  parameter int OP_AW   = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [dl_frame_pkg::BYTE_W-1:0]   node_id,
  input  logic                              in_valid,
  input  logic [dl_frame_pkg::BYTE_W-1:0]   in_data,
  input  logic                              in_sof,
  input  logic                              in_eof,
  output logic                              frame_close,
  output logic                              app_we,
  output logic [ADDR_W-1:0]                 app_addr,
  output logic [dl_frame_pkg::BYTE_W-1:0]   app_wdata,
  output logic                              op_we,
  output logic [OP_AW-1:0]                  op_addr,
  output logic [dl_frame_pkg::RADDR_W+dl_frame_pkg::BYTE_W-1:0] op_wdata
);
  import dl_frame_pkg::*;

  localparam int HW = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;
  localparam logic [HW-1:0] HDR_LAST = HW'(HDR_LEN - 1);

  walk_state_t        st;
  logic [HW-1:0]      hcnt;
  logic               hit;
  logic [RADDR_W-1:0] cur_addr;
  logic [BYTE_W-1:0]  remain;
  logic [OP_AW-1:0]   op_idx;

  assign frame_close = in_valid && in_eof && (in_sof || st != W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      hcnt      <= '0;
      hit       <= 1'b0;
      cur_addr  <= '0;
      remain    <= '0;
      op_idx    <= '0;
      app_we    <= 1'b0;
      app_addr  <= '0;
      app_wdata <= '0;
      op_we     <= 1'b0;
      op_addr   <= '0;
      op_wdata  <= '0;
    end else begin
      app_we <= 1'b0;
      op_we  <= 1'b0;
      if (in_valid) begin
        if (in_sof) begin
          op_idx <= '0;
          hcnt   <= HW'(1);
          st     <= (HDR_LEN > 1) ? W_HEAD : W_TGT;
        end else begin
          unique case (st)
            W_IDLE: st <= W_IDLE;
            W_HEAD: begin
              hcnt <= hcnt + HW'(1);
              if (hcnt == HDR_LAST) st <= W_TGT;
            end
            W_TGT: begin
              if (in_data == LIST_END_ID) begin
                st <= W_TAIL;
              end else begin
                hit <= (in_data == node_id);
                st  <= W_AHI;
              end
            end
            W_AHI: begin
              cur_addr[RADDR_W-1:BYTE_W] <= in_data;
              st <= W_ALO;
            end
            W_ALO: begin
              cur_addr[BYTE_W-1:0] <= in_data;
              st <= W_LEN;
            end
            W_LEN: begin
              remain <= in_data;
              if (hit) begin
                op_we    <= 1'b1;
                op_addr  <= op_idx;
                op_wdata <= {cur_addr, in_data};
                op_idx   <= op_idx + OP_AW'(1);
              end
              st <= (in_data == '0) ? W_TGT : W_BODY;
            end
            W_BODY: begin
              if (hit) begin
                app_we    <= 1'b1;
                app_addr  <= cur_addr[ADDR_W-1:0];
                app_wdata <= in_data;
              end
              cur_addr <= cur_addr + RADDR_W'(1);
              remain   <= remain - BYTE_W'(1);
              if (remain == BYTE_W'(1)) st <= W_TGT;
            end
            W_TAIL: st <= W_TAIL;
            default: st <= W_IDLE;
          endcase
        end
        if (in_eof) st <= W_IDLE;
      end
    end
  end

  // A data write only follows an accepted input byte (R3).
  assert_write_needs_byte_R3: assert property (@(posedge clk) disable iff (rst)
    app_we |-> $past(in_valid));
  // A record's info entry and its payload cannot land in one cycle (R5).
  assert_we_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(app_we && op_we));
  // Records are at least four bytes apart, so info writes never repeat back to back (R5).
  assert_op_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    op_we |=> !op_we);
endmodule

// File: rtl/dl_done_stretch.sv
module dl_done_stretch #(
  parameter int DONE_CYCLES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic done
);
  localparam int CW = $clog2(DONE_CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      done <= 1'b0;
    end else if (fire) begin
      left <= CW'(DONE_CYCLES - 1);
      done <= 1'b1;
    end else if (left != '0) begin
      left <= left - CW'(1);
      done <= 1'b1;
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/dl_frame_splitter.sv
module dl_frame_splitter #(
  parameter int HDR_LEN     = 2,
  parameter int ADDR_W      = 8,
  parameter int OP_DEPTH    = 16,
  parameter int FWD_LAT     = 2,
  parameter int DONE_CYCLES = 12,
  localparam int OP_AW      = $clog2(OP_DEPTH),
  localparam int OPD_W      = dl_frame_pkg::RADDR_W + dl_frame_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        node_id,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  output logic              fwd_valid,
  output logic [7:0]        fwd_data,
  output logic              fwd_sof,
  output logic              fwd_eof,
  output logic              app_we,
  output logic [ADDR_W-1:0] app_addr,
  output logic [7:0]        app_wdata,
  output logic              op_we,
  output logic [OP_AW-1:0]  op_addr,
  output logic [OPD_W-1:0]  op_wdata,
  output logic              rx_done
);
  import dl_frame_pkg::*;

  beat_t in_beat, out_beat;
  logic  frame_close;

  assign in_beat = '{vld: in_valid, sof: in_valid & in_sof,
                     eof: in_valid & in_eof, dat: in_data};

  dl_fwd_delay #(.DEPTH(FWD_LAT)) u_fwd (
    .clk  (clk),
    .rst  (rst),
    .din  (in_beat),
    .dout (out_beat)
  );

  assign fwd_valid = out_beat.vld;
  assign fwd_sof   = out_beat.sof;
  assign fwd_eof   = out_beat.eof;
  assign fwd_data  = out_beat.dat;

  dl_rec_walker #(.HDR_LEN(HDR_LEN), .ADDR_W(ADDR_W), .OP_AW(OP_AW)) u_walk (
    .clk         (clk),
    .rst         (rst),
    .node_id     (node_id),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .frame_close (frame_close),
    .app_we      (app_we),
    .app_addr    (app_addr),
    .app_wdata   (app_wdata),
    .op_we       (op_we),
    .op_addr     (op_addr),
    .op_wdata    (op_wdata)
  );

  dl_done_stretch #(.DONE_CYCLES(DONE_CYCLES)) u_done (
    .clk  (clk),
    .rst  (rst),
    .fire (frame_close & ~in_err),
    .done (rx_done)
  );

  // The strobe starts only after a clean end marker (R8).
  assert_done_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(in_valid && in_eof && !in_err));
  // An errored end marker never starts a strobe from idle (R9).
  assert_err_no_done_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof && in_err && !rx_done) |=> !rx_done);
endmodule

// File: tb/dl_frame_splitter_test.sv
`timescale 1ns/1ps
module dl_frame_splitter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  node_id;
  logic        in_valid, in_sof, in_eof, in_err;
  logic [7:0]  in_data;
  logic        fwd_valid, fwd_sof, fwd_eof;
  logic [7:0]  fwd_data;
  logic        app_we, op_we, rx_done;
  logic [7:0]  app_addr, app_wdata;
  logic [3:0]  op_addr;
  logic [23:0] op_wdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dl_frame_splitter uut (
    .clk(clk), .rst(rst), .node_id(node_id),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_sof(fwd_sof), .fwd_eof(fwd_eof),
    .app_we(app_we), .app_addr(app_addr), .app_wdata(app_wdata),
    .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
    .rx_done(rx_done)
  );

  // Bench-side image of the operation-info RAM.
  logic [23:0] op_log [16];
  always @(negedge clk) if (op_we) op_log[op_addr] = op_wdata;

  // {sof, eof, err, data, exp_app_we, exp_app_addr, exp_op_we, exp_done}
  localparam logic [21:0] VEC [22] = '{
    {1'b1,1'b0,1'b0,8'h03, 1'b0,8'h00, 1'b0,1'b0},  // header byte = node id (R2)
    {1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0},  // header (R2)
    {1'b0,1'b0,1'b0,8'h01, 1'b0,8'h00, 1'b0,1'b0},  // other node (R4)
    {1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h10, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h01, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h03, 1'b0,8'h00, 1'b0,1'b0},  // skipped data looks like id (R4)
    {1'b0,1'b0,1'b0,8'h03, 1'b0,8'h00, 1'b0,1'b0},  // own record
    {1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h20, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h02, 1'b0,8'h00, 1'b1,1'b0},  // info entry 0 (R5)
    {1'b0,1'b0,1'b0,8'h11, 1'b1,8'h20, 1'b0,1'b0},  // (R3)
    {1'b0,1'b0,1'b0,8'h22, 1'b1,8'h21, 1'b0,1'b0},  // (R3)
    {1'b0,1'b0,1'b0,8'h03, 1'b0,8'h00, 1'b0,1'b0},  // zero-length record (R6)
    {1'b0,1'b0,1'b0,8'h01, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'hF0, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0},  // info entry 1 (R6)
    {1'b0,1'b0,1'b0,8'h03, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h40, 1'b0,8'h00, 1'b0,1'b0},
    {1'b0,1'b0,1'b0,8'h01, 1'b0,8'h00, 1'b1,1'b0},  // info entry 2 (R5)
    {1'b0,1'b1,1'b0,8'h5A, 1'b1,8'h40, 1'b0,1'b1}   // write and done together (R3, R8)
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic e,
                       input logic r, input logic [7:0] d);
    in_valid = v; in_sof = s; in_eof = e; in_err = r; in_data = d;
  endtask

  int wr_seen;
  task automatic send(input logic s, input logic e, input logic r, input logic [7:0] d);
    drive(1'b1, s, e, r, d);
    @(negedge clk);
    if (app_we || op_we) wr_seen++;
  endtask

  function automatic int count_done(input int first);
    return first;
  endfunction

  int hi;

  initial begin
    rst = 1'b1;
    node_id = 8'h03;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    chk({fwd_valid, app_we, op_we, rx_done} == 4'b0, "R10 in reset",
        {fwd_valid, app_we, op_we, rx_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({fwd_valid, fwd_sof, fwd_eof, app_we, op_we, rx_done} == 6'b0, "R10 after reset",
        {fwd_valid, fwd_sof, fwd_eof, app_we, op_we, rx_done}, 0);

    // Frame A: table walk
    for (int i = 0; i < 22; i++) begin
      drive(1'b1, VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18:11]);
      @(negedge clk);
      chk(app_we == VEC[i][10], "R3/R4 app_we", app_we, VEC[i][10]);
      if (VEC[i][10]) begin
        chk(app_addr == VEC[i][9:2], "R3 app_addr", app_addr, VEC[i][9:2]);
        chk(app_wdata == VEC[i][18:11], "R3 app_wdata", app_wdata, VEC[i][18:11]);
      end
      chk(op_we == VEC[i][1], "R5/R2 op_we", op_we, VEC[i][1]);
      chk(rx_done == VEC[i][0], "R8 done timing", rx_done, VEC[i][0]);
      if (i > 0)
        chk({fwd_valid, fwd_sof, fwd_eof, fwd_data} ==
            {1'b1, VEC[i-1][21], VEC[i-1][20], VEC[i-1][18:11]}, "R1 forward",
            {fwd_valid, fwd_sof, fwd_eof, fwd_data},
            {1'b1, VEC[i-1][21], VEC[i-1][20], VEC[i-1][18:11]});
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk({fwd_valid, fwd_eof, fwd_data} == {1'b1, 1'b1, 8'h5A}, "R1 forward last",
        {fwd_valid, fwd_eof, fwd_data}, {1'b1, 1'b1, 8'h5A});
    hi = 1 + (rx_done ? 1 : 0);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (rx_done) hi++;
    end
    chk(hi == 12, "R8 done width", hi, 12);
    chk(fwd_valid == 1'b0, "R1 idle forward", fwd_valid, 0);
    chk(op_log[0] == 24'h002002, "R5 entry 0", op_log[0], 24'h002002);
    chk(op_log[1] == 24'h01F000, "R6 entry 1", op_log[1], 24'h01F000);
    chk(op_log[2] == 24'h004001, "R5 entry 2", op_log[2], 24'h004001);

    // Frame B: end of list, then a tail that looks like an own record (R7)
    wr_seen = 0;
    send(1'b1, 1'b0, 1'b0, 8'h00);
    send(1'b0, 1'b0, 1'b0, 8'h00);
    send(1'b0, 1'b0, 1'b0, 8'hFF);
    send(1'b0, 1'b0, 1'b0, 8'h03);
    send(1'b0, 1'b0, 1'b0, 8'h00);
    send(1'b0, 1'b0, 1'b0, 8'h50);
    send(1'b0, 1'b0, 1'b0, 8'h01);
    send(1'b0, 1'b1, 1'b0, 8'h99);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    hi = rx_done ? 1 : 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (app_we || op_we) wr_seen++;
      if (rx_done) hi++;
    end
    chk(wr_seen == 0, "R7 no writes after end id", wr_seen, 0);
    chk(hi == 12, "R8 done width frame B", hi, 12);

    // Frame C: errored end; last byte is own payload (R9)
    wr_seen = 0;
    hi = 0;
    send(1'b1, 1'b0, 1'b0, 8'h00);
    send(1'b0, 1'b0, 1'b0, 8'h00);
    send(1'b0, 1'b0, 1'b0, 8'h03);
    send(1'b0, 1'b0, 1'b0, 8'h00);
    send(1'b0, 1'b0, 1'b0, 8'h60);
    send(1'b0, 1'b0, 1'b0, 8'h01);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h33);
    @(negedge clk);
    chk({app_we, app_addr, app_wdata} == {1'b1, 8'h60, 8'h33}, "R9 write kept",
        {app_we, app_addr, app_wdata}, {1'b1, 8'h60, 8'h33});
    if (rx_done) hi++;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (rx_done) hi++;
    end
    chk(hi == 0, "R9 no done on error", hi, 0);
    chk(op_log[0] == 24'h006001, "R5 index restarts", op_log[0], 24'h006001);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule